// File: doc/BRIEF.md
# Multiple-Register Transfer Sequencer

This block turns a single block-transfer command into a string of one-word memory accesses. A command carries a 16-bit register selection mask, a 32-bit base address, an addressing direction, a writeback enable and a load/store flag. The block walks the mask from the lowest-numbered selected register to the highest and issues one memory beat per selected register. Each beat presents the register index and the word address, and the beat completes on a valid/ready handshake.

On a load, the read data of each completed beat goes straight to the register file write port, together with that beat's register index and a write strobe. On a store, the register file read data for the presented index is forwarded as the memory write data. After the last beat the block raises a one-cycle done pulse. When writeback was requested, the new base value is presented alongside that pulse.

Two address modes are supported: ascending (access, then step up one word) and descending (step down one word, then access). In both modes the lowest-numbered register sits at the lowest address, so the descending mode starts at base minus four times the register count and then counts upward. The writeback and non-writeback forms of a command touch exactly the same words.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset the block is idle: cmd_ready is 1, and mem_valid, done, wb_valid and rf_we are 0.
- R2: An accepted command produces exactly one beat per set bit of cmd_mask, presented in ascending register index order (reg_idx is the bit position).
- R3: With cmd_dec=0 (ascending), the first beat's address is cmd_base, and each later beat's address is 4 more than the previous one.
- R4: With cmd_dec=1 (descending), the first beat's address is cmd_base minus 4×N, where N is the number of set mask bits, and each later beat's address is 4 more than the previous one.
- R5: With cmd_wb=1 and a non-zero mask, wb_valid is high in the done cycle and wb_base is cmd_base+4×N (ascending) or cmd_base−4×N (descending). For example, base 0x8000 with mask 0x000F ascending gives 0x8010. With cmd_wb=0, wb_valid stays 0.
- R6: Two commands that differ only in cmd_wb access the same sequence of addresses.
- R7: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr and reg_idx hold their values.
- R8: For a load (cmd_load=1), rf_we is 1 exactly in the cycles where mem_valid and mem_ready are both 1, and rf_wdata equals mem_rdata. For a store, mem_write is 1, mem_wdata equals rf_rdata, and rf_we stays 0.
- R9: done is a single-cycle pulse in the cycle after the last beat's handshake. cmd_ready is 0 from the cycle after acceptance through the done cycle, so commands presented meanwhile are ignored.
- R10: An all-zero mask gives a done pulse in the cycle after acceptance, with no beat and with wb_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle; command accepted when both high |
| cmd_mask | input | 16 | Register selection mask |
| cmd_base | input | 32 | Base address |
| cmd_dec | input | 1 | 1 = descending (step before), 0 = ascending (step after) |
| cmd_wb | input | 1 | Request updated base at completion |
| cmd_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| mem_valid | output | 1 | Beat request |
| mem_ready | input | 1 | Beat accepted by memory |
| mem_addr | output | 32 | Word address of the beat |
| mem_write | output | 1 | Beat is a write |
| mem_wdata | output | 32 | Write data (store) |
| mem_rdata | input | 32 | Read data (load) |
| reg_idx | output | 4 | Register index of the current beat |
| rf_rdata | input | 32 | Register file read data for reg_idx |
| rf_we | output | 1 | Register file write strobe |
| rf_wdata | output | 32 | Register file write data |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Base writeback strobe |
| wb_base | output | 32 | New base value |

## Verification
The hardest condition to reach is a stalled final beat followed at once by a waiting command. This checks that the command held on the inputs during the busy cycles is ignored, and that it starts only after the done pulse. The stimulus keeps a command queue that holds cmd_valid high continuously and throttles mem_ready per command: always ready, random ready, or ready one cycle in four. Mask patterns include the single top bit, both ends, the full mask and zero. A cycle-level queue model predicts every output on every clock.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FIN  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/blkxfer_popcount.sv
module blkxfer_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] part [N+1];

    assign part[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_sum
        assign part[i+1] = part[i] + CW'(vec[i]);
    end

    assign cnt = part[N];
endmodule

// File: rtl/blkxfer_lowbit.sv
module blkxfer_lowbit #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/blkxfer_addr_plan.sv
module blkxfer_addr_plan #(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] cnt,
    input  logic          dec,
    output logic [AW-1:0] first_addr,
    output logic [AW-1:0] final_base
);
    localparam int SH = $clog2(WORD_BYTES);

    logic [AW-1:0] span;

    always_comb begin
        span       = AW'(cnt) << SH;
        first_addr = dec ? (base - span) : base;
        final_base = dec ? (base - span) : (base + span);
    end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
    import blkxfer_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [NREG-1:0]         cmd_mask,
    input  logic [AW-1:0]           cmd_base,
    input  logic                    cmd_dec,
    input  logic                    cmd_wb,
    input  logic                    cmd_load,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [AW-1:0]           mem_addr,
    output logic                    mem_write,
    output logic [DW-1:0]           mem_wdata,
    input  logic [DW-1:0]           mem_rdata,
    output logic [$clog2(NREG)-1:0] reg_idx,
    input  logic [DW-1:0]           rf_rdata,
    output logic                    rf_we,
    output logic [DW-1:0]           rf_wdata,
    output logic                    done,
    output logic                    wb_valid,
    output logic [AW-1:0]           wb_base
);
    localparam int IW = $clog2(NREG);
    localparam int CW = $clog2(NREG + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [NREG-1:0] rem;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   fin;
        logic            load;
        logic            wb;
        logic            nz;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [CW-1:0] sel_cnt_d;
    logic [AW-1:0] first_addr_d;
    logic [AW-1:0] final_base_d;
    logic [IW-1:0] cur_idx_d;

    blkxfer_popcount #(.N(NREG), .CW(CW)) u_count (
        .vec (cmd_mask),
        .cnt (sel_cnt_d)
    );

    blkxfer_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base       (cmd_base),
        .cnt        (sel_cnt_d),
        .dec        (cmd_dec),
        .first_addr (first_addr_d),
        .final_base (final_base_d)
    );

    blkxfer_lowbit #(.N(NREG), .IW(IW)) u_pick (
        .vec (ctx_q.rem),
        .idx (cur_idx_d)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            SEQ_IDLE: begin
                if (cmd_valid) begin
                    ctx_d.rem  = cmd_mask;
                    ctx_d.addr = first_addr_d;
                    ctx_d.fin  = final_base_d;
                    ctx_d.load = cmd_load;
                    ctx_d.wb   = cmd_wb;
                    ctx_d.nz   = |cmd_mask;
                    ctx_d.st   = (|cmd_mask) ? SEQ_RUN : SEQ_FIN;
                end
            end
            SEQ_RUN: begin
                if (mem_ready) begin
                    ctx_d.rem  = ctx_q.rem & (ctx_q.rem - NREG'(1));
                    ctx_d.addr = ctx_q.addr + AW'(WORD_BYTES);
                    if (ctx_d.rem == '0) ctx_d.st = SEQ_FIN;
                end
            end
            SEQ_FIN: begin
                ctx_d.st = SEQ_IDLE;
            end
            default: begin
                ctx_d.st = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '{st: SEQ_IDLE, rem: '0, addr: '0, fin: '0,
                       load: 1'b0, wb: 1'b0, nz: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign cmd_ready = (ctx_q.st == SEQ_IDLE);
    assign mem_valid = (ctx_q.st == SEQ_RUN);
    assign mem_addr  = ctx_q.addr;
    assign mem_write = ~ctx_q.load;
    assign mem_wdata = rf_rdata;
    assign reg_idx   = cur_idx_d;
    assign rf_we     = mem_valid & mem_ready & ctx_q.load;
    assign rf_wdata  = mem_rdata;
    assign done      = (ctx_q.st == SEQ_FIN);
    assign wb_valid  = done & ctx_q.wb & ctx_q.nz;
    assign wb_base   = ctx_q.fin;
endmodule

// File: rtl/blkxfer_seq_chk.sv
module blkxfer_seq_chk #(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_ready,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [AW-1:0]           mem_addr,
    input logic                    mem_write,
    input logic [$clog2(NREG)-1:0] reg_idx,
    input logic                    rf_we,
    input logic                    done,
    input logic                    wb_valid
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_valid && !done && !rf_we));

    p_idx_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (reg_idx > $past(reg_idx))));

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + AW'(WORD_BYTES))));

    p_wb_in_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(reg_idx)));

    p_load_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_valid && mem_ready && !mem_write));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!cmd_ready && !mem_valid));
endmodule

bind blkxfer_seq blkxfer_seq_chk #(.NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)) u_chk (.*);

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready;
    logic [15:0] cmd_mask;
    logic [31:0] cmd_base;
    logic        cmd_dec, cmd_wb, cmd_load;
    logic        mem_valid, mem_ready, mem_write;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, wb_base;
    logic [3:0]  reg_idx;
    logic        rf_we, done, wb_valid;

    always #2 clk = ~clk;

    blkxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mask(cmd_mask), .cmd_base(cmd_base), .cmd_dec(cmd_dec), .cmd_wb(cmd_wb),
        .cmd_load(cmd_load), .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_write(mem_write), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .reg_idx(reg_idx), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .done(done), .wb_valid(wb_valid), .wb_base(wb_base)
    );

    typedef struct {
        logic [15:0] mask;
        logic [31:0] base;
        bit dec, wb, load, cmp;
        int rdy;
    } cmd_t;

    cmd_t cq[$];
    cmd_t cur;
    int   checks = 0, errors = 0;

    // reference model state
    bit          m_idle, m_done, m_nz;
    int          m_q[$];
    logic [31:0] m_addr, m_fin;
    int unsigned acc[$], prev_acc[$];
    bit          prev_stall;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic cmd_t mk(logic [15:0] m, logic [31:0] b, bit d, bit w, bit l, bit c, int r);
        cmd_t x;
        x.mask = m; x.base = b; x.dec = d; x.wb = w; x.load = l; x.cmp = c; x.rdy = r;
        return x;
    endfunction

    initial begin
        int cyc;
        int n;
        rst_n = 1'b0; cmd_valid = 0; cmd_mask = 0; cmd_base = 0; cmd_dec = 0;
        cmd_wb = 0; cmd_load = 0; mem_ready = 0; mem_rdata = 0; rf_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        chk("R1 cmd_ready", {31'd0, cmd_ready}, 32'd1);
        chk("R1 mem_valid", {31'd0, mem_valid}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 wb_valid", {31'd0, wb_valid}, 32'd0);
        chk("R1 rf_we", {31'd0, rf_we}, 32'd0);

        cq.push_back(mk(16'h000F, 32'h8000, 0, 1, 1, 0, 0));
        cq.push_back(mk(16'h000F, 32'h8000, 0, 0, 1, 1, 1));
        cq.push_back(mk(16'h000F, 32'h8000, 1, 1, 0, 0, 1));
        cq.push_back(mk(16'h000F, 32'h8000, 1, 0, 0, 1, 2));
        cq.push_back(mk(16'h0000, 32'h1234, 0, 1, 1, 0, 0));
        cq.push_back(mk(16'hFFFF, 32'h2000_0000, 0, 1, 1, 0, 2));
        cq.push_back(mk(16'h8001, 32'h0000_0100, 1, 1, 0, 0, 1));
        cq.push_back(mk(16'h8000, 32'h0000_4000, 0, 1, 1, 0, 2));
        cq.push_back(mk(16'hA5C3, 32'h0001_0000, 1, 0, 1, 0, 2));
        cq.push_back(mk(16'h0000, 32'h0000_0040, 1, 0, 0, 0, 1));
        for (int k = 0; k < 24; k++) begin
            cmd_t r;
            r = mk(16'($urandom), {$urandom} & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom),
                   1'($urandom), 0, int'($urandom % 3));
            cq.push_back(r);
            if (k % 4 == 0) begin
                r.wb = ~r.wb; r.cmp = 1; r.rdy = (r.rdy + 1) % 3;
                cq.push_back(r);
            end
        end

        m_idle = 1; m_done = 0; m_nz = 0; prev_stall = 0;
        cur = cq[0];
        cyc = 0;
        while ((cq.size() > 0 || !m_idle) && cyc < 20000) begin
            @(negedge clk);
            if (cq.size() > 0) begin
                cmd_valid = 1; cmd_mask = cq[0].mask; cmd_base = cq[0].base;
                cmd_dec = cq[0].dec; cmd_wb = cq[0].wb; cmd_load = cq[0].load;
            end else begin
                cmd_valid = 0;
            end
            case (cur.rdy)
                0: mem_ready = 1'b1;
                1: mem_ready = 1'($urandom);
                default: mem_ready = (($urandom % 4) == 0);
            endcase
            mem_rdata = $urandom;
            rf_rdata  = $urandom;
            #0.5;

            // compare outputs with the model
            chk("R9 cmd_ready", {31'd0, cmd_ready}, {31'd0, m_idle});
            chk("R2 mem_valid", {31'd0, mem_valid}, {31'd0, (m_q.size() > 0)});
            chk("R9 done", {31'd0, done}, {31'd0, m_done});
            chk("R5 wb_valid", {31'd0, wb_valid}, {31'd0, m_done && cur.wb && m_nz});
            if (m_done && !m_nz) chk("R10 no wb on empty mask", {31'd0, wb_valid}, 32'd0);
            if (m_done && cur.wb && m_nz) begin
                chk("R5 wb_base", wb_base, m_fin);
                if (cur.mask == 16'h000F && cur.base == 32'h8000 && !cur.dec)
                    chk("R5 wb_base 0x8010", wb_base, 32'h8010);
            end
            if (m_q.size() > 0) begin
                chk("R2 reg_idx", {28'd0, reg_idx}, m_q[0]);
                chk(prev_stall ? "R7 held addr" : (cur.dec ? "R4 mem_addr" : "R3 mem_addr"),
                    mem_addr, m_addr);
                chk("R8 mem_write", {31'd0, mem_write}, {31'd0, !cur.load});
                if (!cur.load) chk("R8 mem_wdata", mem_wdata, rf_rdata);
            end
            chk("R8 rf_we", {31'd0, rf_we}, {31'd0, (m_q.size() > 0) && mem_ready && cur.load});
            if (rf_we) chk("R8 rf_wdata", rf_wdata, mem_rdata);

            // advance the model to the next edge
            prev_stall = (m_q.size() > 0) && !mem_ready;
            if (m_idle && cmd_valid) begin
                cur = cq.pop_front();
                m_q.delete();
                for (int b = 0; b < 16; b++) if (cur.mask[b]) m_q.push_back(b);
                n = m_q.size();
                m_addr = cur.dec ? cur.base - 32'(4 * n) : cur.base;
                m_fin  = cur.dec ? cur.base - 32'(4 * n) : cur.base + 32'(4 * n);
                m_nz   = (n != 0);
                m_done = (n == 0);
                m_idle = 0;
                acc.delete();
            end else if (m_q.size() > 0) begin
                if (mem_ready) begin
                    acc.push_back(m_addr);
                    void'(m_q.pop_front());
                    m_addr = m_addr + 32'd4;
                    if (m_q.size() == 0) m_done = 1;
                end
            end else if (m_done) begin
                m_done = 0;
                m_idle = 1;
                if (cur.cmp) begin
                    chk("R6 access count", acc.size(), prev_acc.size());
                    foreach (acc[i]) if (i < prev_acc.size()) chk("R6 same address", acc[i], prev_acc[i]);
                end
                prev_acc = acc;
            end
            cyc++;
        end
        if (cyc >= 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        end
        cmd_valid = 0;
        repeat (2) begin
            @(negedge clk); #0.5;
            chk("R1 idle after run", {30'd0, cmd_ready, mem_valid}, 32'd2);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule